// File: doc/BRIEF.md
# ADC Cross-Trigger Delay Unit

This block sits between a set of timer event sources and an analog-to-digital converter. Each event input has its own delay channel. A rising event flag starts that channel. The channel loads a programmed start value into a 9-bit down-counter. The counter is clocked by a power-of-two prescaler chosen for that channel. When the count runs out, the channel asks for service. One clock later, the block sends a single-cycle conversion trigger to the converter. In the same cycle it tells the converter which event caused the trigger and pulses an acknowledge line back to that event's source, so the source can drop its flag.

A shared arbiter serves the channels that are waiting for service. It picks the lowest-numbered waiting channel first and issues at most one trigger per cycle. While the converter reports that it is busy, the arbiter issues nothing, and waiting channels keep their requests. Every trigger sets a sticky interrupt status bit. Software clears the bit by writing a one to it, and an enable input gates it onto the interrupt line.

Top module: `xtrig_delay_unit`

## Requirements
- R1: After synchronous reset, `trig_o`, `ev_ack`, `irq_stat` and `irq` are all low.
- R2: A channel arms only when the registered copy of its flag goes from 0 to 1 while the channel is idle. A further rising flag on a channel that is already counting or waiting for service has no effect on when it triggers or on how many triggers it gives.
- R3: Let start value S and prescaler code k be applied. If a flag is first seen high at clock edge n, `trig_o` is high for one cycle, launched at edge n + (S+1)·2^k + 1. That is one cycle after the count expires at edge n + (S+1)·2^k.
- R4: The 4-bit prescaler code k makes the counter step once every 2^k clocks. A start value of 0 expires on the first prescaled tick after arming.
- R5: With each trigger, `trig_idx` gives the binary number of the event served, and `ev_ack` is one-hot with only bit `trig_idx` set. When no trigger is issued, `ev_ack` is all zero.
- R6: If `adc_busy` is high at a clock edge, no trigger is launched at that edge. A channel waiting for service keeps its request and is served at the first edge where `adc_busy` is low.
- R7: Channels that wait for service at the same time are served one per cycle, in ascending event number, on consecutive cycles.
- R8: Each trigger sets `irq_stat`, and `irq` equals `irq_stat` AND `irq_en`.
- R9: `irq_clr` high at an edge clears `irq_stat`. A trigger launched at that same edge wins, and `irq_stat` stays 1.
- R10: Each event has its own start value and prescaler, written through `cfg_we`/`cfg_idx`. The values are captured when the channel arms, so a write to a running channel takes effect only from its next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_flag | input | NUM_EV | Event flags from timer sources, held high until acknowledged |
| cfg_we | input | 1 | Write strobe for per-event configuration |
| cfg_idx | input | IDX_W | Event number being configured |
| cfg_start | input | 9 | Down-counter start value |
| cfg_psc | input | 4 | Prescaler code k, divide by 2^k |
| irq_en | input | 1 | Interrupt enable (mask) |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt status |
| adc_busy | input | 1 | Converter reports a conversion in progress |
| trig_o | output | 1 | One-cycle conversion trigger |
| trig_idx | output | IDX_W | Event number of the current trigger |
| ev_ack | output | NUM_EV | One-hot flag-clear acknowledge to the source |
| irq_stat | output | 1 | Sticky interrupt status |
| irq | output | 1 | Masked interrupt request |

## Verification
Two kinds of same-cycle collision matter here. The first is two channels whose counts run out at the same edge. The bench provokes this with identical settings and also with different start values and prescaler codes that reach expiry together. It judges the result by the exact cycle and event number of each logged trigger. The second is a software clear of the interrupt status that lands on the edge where a trigger is launched. The bench times `irq_clr` to that edge and expects the status to remain set.

// File: rtl/xtd_pkg.sv
package xtd_pkg;

    localparam int DLY_W = 9;
    localparam int PSC_W = 4;
    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [DLY_W-1:0] start;
        logic [PSC_W-1:0] psc;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_PEND = 2'd2
    } ch_state_e;

    function automatic logic [DIV_W-1:0] div_limit(input logic [PSC_W-1:0] k);
        return DIV_W'((32'd1 << k) - 32'd1);
    endfunction

endpackage

// File: rtl/xtd_cfg_bank.sv
module xtd_cfg_bank
    import xtd_pkg::*;
#(
    parameter int NUM_EV = 64,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DLY_W-1:0]       start,
    input  logic [PSC_W-1:0]       psc,
    output chan_cfg_t [NUM_EV-1:0] cfg_o
);

    chan_cfg_t [NUM_EV-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (we && (32'(idx) < NUM_EV)) begin
            bank_q[idx] <= '{start: start, psc: psc};
        end
    end

    assign cfg_o = bank_q;

endmodule

// File: rtl/xtd_delay_chan.sv
module xtd_delay_chan
    import xtd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flag,
    input  chan_cfg_t cfg,
    input  logic      served,
    output logic      pend
);

    ch_state_e        state_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [PSC_W-1:0] psc_q;
    logic             flag_q;
    logic             arm;
    logic             tick;

    assign arm  = flag && !flag_q;
    assign tick = (div_q == div_limit(psc_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            div_q   <= '0;
            psc_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            flag_q <= flag;
            unique case (state_q)
                CH_IDLE: begin
                    if (arm) begin
                        state_q <= CH_RUN;
                        cnt_q   <= cfg.start;
                        psc_q   <= cfg.psc;
                        div_q   <= '0;
                    end
                end
                CH_RUN: begin
                    if (tick) begin
                        div_q <= '0;
                        if (cnt_q == '0) begin
                            state_q <= CH_PEND;
                        end else begin
                            cnt_q <= cnt_q - DLY_W'(1);
                        end
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                CH_PEND: begin
                    if (served) begin
                        state_q <= CH_IDLE;
                    end
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    assign pend = (state_q == CH_PEND);

endmodule

// File: rtl/xtd_arbiter.sv
module xtd_arbiter #(
    parameter int NUM_EV = 64,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] pend,
    input  logic              adc_busy,
    input  logic              irq_clr,
    input  logic              irq_en,
    output logic [NUM_EV-1:0] served,
    output logic              trig_o,
    output logic [IDX_W-1:0]  trig_idx,
    output logic [NUM_EV-1:0] ev_ack,
    output logic              irq_stat,
    output logic              irq
);

    logic [IDX_W-1:0] sel;
    logic             grant;

    always_comb begin
        sel = '0;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (pend[i]) sel = IDX_W'(i);
        end
    end

    assign grant = (|pend) && !adc_busy;

    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_srv
            assign served[g] = grant && (sel == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_o   <= 1'b0;
            trig_idx <= '0;
            ev_ack   <= '0;
            irq_stat <= 1'b0;
        end else begin
            trig_o   <= grant;
            trig_idx <= sel;
            ev_ack   <= served;
            if (grant)        irq_stat <= 1'b1;
            else if (irq_clr) irq_stat <= 1'b0;
        end
    end

    assign irq = irq_stat && irq_en;

endmodule

// File: rtl/xtrig_delay_unit.sv
module xtrig_delay_unit
    import xtd_pkg::*;
#(
    parameter int NUM_EV = 64,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_flag,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [8:0]        cfg_start,
    input  logic [3:0]        cfg_psc,
    input  logic              irq_en,
    input  logic              irq_clr,
    input  logic              adc_busy,
    output logic              trig_o,
    output logic [IDX_W-1:0]  trig_idx,
    output logic [NUM_EV-1:0] ev_ack,
    output logic              irq_stat,
    output logic              irq
);

    chan_cfg_t [NUM_EV-1:0] cfg;
    logic      [NUM_EV-1:0] pend;
    logic      [NUM_EV-1:0] served;

    xtd_cfg_bank #(.NUM_EV(NUM_EV)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .start (cfg_start),
        .psc   (cfg_psc),
        .cfg_o (cfg)
    );

    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_ch
            xtd_delay_chan u_ch (
                .clk    (clk),
                .rst    (rst),
                .flag   (ev_flag[g]),
                .cfg    (cfg[g]),
                .served (served[g]),
                .pend   (pend[g])
            );
        end
    endgenerate

    xtd_arbiter #(.NUM_EV(NUM_EV)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .adc_busy (adc_busy),
        .irq_clr  (irq_clr),
        .irq_en   (irq_en),
        .served   (served),
        .trig_o   (trig_o),
        .trig_idx (trig_idx),
        .ev_ack   (ev_ack),
        .irq_stat (irq_stat),
        .irq      (irq)
    );

endmodule

// File: rtl/xtrig_delay_unit_chk.sv
module xtrig_delay_unit_chk #(
    parameter int NUM_EV = 64,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              adc_busy,
    input logic              trig_o,
    input logic [IDX_W-1:0]  trig_idx,
    input logic [NUM_EV-1:0] ev_ack,
    input logic              irq_stat,
    input logic              irq
);

    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> ($countones(ev_ack) == 1));

    p_ack_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !trig_o |-> (ev_ack == '0));

    p_ack_matches_idx_r5: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> ev_ack[trig_idx]);

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        adc_busy |=> !trig_o);

    p_trig_sets_irq_r8: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> irq_stat);

    p_irq_needs_stat_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_stat);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> (!irq_stat || trig_o));

    p_stat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_stat && !irq_clr) |=> irq_stat);

endmodule

bind xtrig_delay_unit xtrig_delay_unit_chk #(.NUM_EV(NUM_EV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (irq_en),
    .irq_clr  (irq_clr),
    .adc_busy (adc_busy),
    .trig_o   (trig_o),
    .trig_idx (trig_idx),
    .ev_ack   (ev_ack),
    .irq_stat (irq_stat),
    .irq      (irq)
);

// File: tb/xtrig_delay_unit_test.sv
`timescale 1ns/1ps
module xtrig_delay_unit_test;

    localparam int NEV = 4;
    localparam int IW  = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic [NEV-1:0] ev_flag;
    logic           cfg_we;
    logic [IW-1:0]  cfg_idx;
    logic [8:0]     cfg_start;
    logic [3:0]     cfg_psc;
    logic           irq_en;
    logic           irq_clr;
    logic           adc_busy;
    logic           trig_o;
    logic [IW-1:0]  trig_idx;
    logic [NEV-1:0] ev_ack;
    logic           irq_stat;
    logic           irq;

    xtrig_delay_unit #(.NUM_EV(NEV)) uut (
        .clk(clk), .rst(rst), .ev_flag(ev_flag), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_start(cfg_start), .cfg_psc(cfg_psc),
        .irq_en(irq_en), .irq_clr(irq_clr), .adc_busy(adc_busy),
        .trig_o(trig_o), .trig_idx(trig_idx), .ev_ack(ev_ack),
        .irq_stat(irq_stat), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int log_n  = 0;
    int log_cyc [64];
    int log_idx [64];
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // one clock: ends at the falling edge, logs triggers, source drops acked flags
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (trig_o) begin
            check(ev_ack == (NEV'(1) << trig_idx), "R5 ack one-hot at index",
                  int'(ev_ack), int'(NEV'(1) << trig_idx));
            if (log_n < 64) begin
                log_cyc[log_n] = cyc;
                log_idx[log_n] = int'(trig_idx);
            end
            log_n++;
            ev_flag = ev_flag & ~ev_ack;
        end else begin
            check(ev_ack == '0, "R5 no ack without trigger", int'(ev_ack), 0);
        end
    endtask

    task automatic run_to(input int t);
        while (cyc < t) tick();
    endtask

    task automatic wr(input int ch, input int s, input int k);
        cfg_we    = 1'b1;
        cfg_idx   = IW'(ch);
        cfg_start = 9'(s);
        cfg_psc   = 4'(k);
        tick();
        cfg_we    = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            report();
            $finish;
        end
    end

    initial begin
        int c;
        int e;
        rst = 1'b1; ev_flag = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_start = '0;
        cfg_psc = '0; irq_en = 1'b0; irq_clr = 1'b0; adc_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!trig_o, "R1 trig_o", int'(trig_o), 0);
        check(ev_ack == '0, "R1 ev_ack", int'(ev_ack), 0);
        check(!irq_stat, "R1 irq_stat", int'(irq_stat), 0);
        check(!irq, "R1 irq", int'(irq), 0);
        rst = 1'b0;

        // R3 / R4 sweep of start value and prescaler code
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 4; k++) begin
                int ch;
                ch = (s + k) % NEV;
                wr(ch, s, k);
                log_n = 0;
                c = cyc;
                e = c + ((s + 1) << k) + 2;
                ev_flag[ch] = 1'b1;
                run_to(e + 3);
                check(log_n == 1, "R3 single trigger", log_n, 1);
                check(log_cyc[0] == e, (k == 0) ? "R3 delay timing" : "R4 prescaled timing",
                      log_cyc[0] - c, e - c);
                check(log_idx[0] == ch, "R5 trig_idx", log_idx[0], ch);
            end
        end

        // R8 status set and masking
        check(irq_stat, "R8 status set", int'(irq_stat), 1);
        check(!irq, "R8 masked irq", int'(irq), 0);
        irq_en = 1'b1;
        tick();
        check(irq, "R8 enabled irq", int'(irq), 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check(!irq_stat, "R9 w1c clears", int'(irq_stat), 0);
        check(!irq, "R9 irq drops", int'(irq), 0);

        // R2 rising flag while running is ignored
        wr(2, 4, 0);
        log_n = 0;
        c = cyc;
        ev_flag[2] = 1'b1;
        run_to(c + 2);
        ev_flag[2] = 1'b0;
        tick();
        ev_flag[2] = 1'b1;
        run_to(c + 16);
        check(log_n == 1, "R2 no re-arm", log_n, 1);
        check(log_cyc[0] == c + 7, "R2 timing kept", log_cyc[0] - c, 7);
        ev_flag = '0;
        tick();

        // R10 config write while running takes effect from next arming
        wr(0, 3, 0);
        log_n = 0;
        c = cyc;
        ev_flag[0] = 1'b1;
        tick();
        wr(0, 0, 0);
        run_to(c + 12);
        check(log_n == 1 && log_cyc[0] == c + 6, "R10 old value used",
              log_cyc[0] - c, 6);
        log_n = 0;
        c = cyc;
        ev_flag[0] = 1'b1;
        run_to(c + 8);
        check(log_n == 1 && log_cyc[0] == c + 3, "R10 new value used",
              log_cyc[0] - c, 3);

        // R6 busy converter holds the trigger
        wr(1, 2, 0);
        adc_busy = 1'b1;
        log_n = 0;
        c = cyc;
        ev_flag[1] = 1'b1;
        run_to(c + 10);
        check(log_n == 0, "R6 held while busy", log_n, 0);
        adc_busy = 1'b0;
        run_to(c + 15);
        check(log_n == 1 && log_cyc[0] == c + 11, "R6 released", log_cyc[0] - c, 11);
        check(log_idx[0] == 1, "R6 index", log_idx[0], 1);

        // R7 identical expiry, ascending service
        for (int i = 0; i < NEV; i++) wr(i, 1, 0);
        log_n = 0;
        c = cyc;
        ev_flag = 4'b1111;
        run_to(c + 12);
        check(log_n == NEV, "R7 trigger count", log_n, NEV);
        for (int i = 0; i < NEV; i++) begin
            check(log_idx[i] == i, "R7 order", log_idx[i], i);
            check(log_cyc[i] == c + 4 + i, "R7 cycle", log_cyc[i] - c, 4 + i);
        end

        // R7 different settings reaching the same expiry edge
        wr(3, 3, 0);
        wr(0, 1, 1);
        log_n = 0;
        c = cyc;
        ev_flag = 4'b1001;
        run_to(c + 12);
        check(log_n == 2, "R7 mixed count", log_n, 2);
        check(log_idx[0] == 0 && log_cyc[0] == c + 6, "R7 mixed first",
              log_cyc[0] - c, 6);
        check(log_idx[1] == 3 && log_cyc[1] == c + 7, "R7 mixed second",
              log_cyc[1] - c, 7);

        // R9 clear at the trigger edge: set wins
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check(!irq_stat, "R9 pre-clear", int'(irq_stat), 0);
        wr(2, 0, 0);
        log_n = 0;
        c = cyc;
        ev_flag[2] = 1'b1;
        run_to(c + 2);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check(log_n == 1 && log_cyc[0] == c + 3, "R9 trigger edge", log_cyc[0] - c, 3);
        check(irq_stat, "R9 set wins over clear", int'(irq_stat), 1);
        run_to(c + 6);

        done = 1'b1;
        report();
        $finish;
    end

endmodule